// File: doc/BRIEF.md
# Warp Shuffle-Down Sum Reduction

This block adds up one 32-bit value from each of the 32 lanes of a warp. The lanes exchange data only between registers, with no scratchpad and no barrier. A single start pulse hands over the whole lane vector and a participation mask. The block then runs five exchange steps with halving offsets: 16, then 8, 4, 2 and 1. In every step, each lane adds in the value held by the lane that sits the current offset above it. A lane whose partner index would be 32 or more keeps its own value for that step. After the fifth step, lane 0 holds the warp total. That total is presented on a registered output together with a one-cycle done pulse.

The first exchange is applied directly to the incoming lane vector in the cycle the start is accepted, and each later step takes one further clock. A mask that does not cover every lane aborts the operation. In that case an error pulse is raised, and neither a done pulse nor a new sum appears. Addition is plain 32-bit two's complement and wraps on overflow.

Top module: `warp_shfl_reduce`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `err` and `sum` are all zero until the first operation.
- R2: A start accepted at the clock edge ending cycle c (idle, `mask` = 0xFFFFFFFF) makes `done` high in cycle c+5, and `done` stays low in cycles c+1 to c+4; `busy` is high in cycles c+1 to c+4 and low in cycle c+5.
- R3: The `sum` presented with `done` equals the modulo-2^32 sum of all 32 lane values, where lane i occupies bits [32*i+31 : 32*i] of `lanes_in`.
- R4: Lane values are captured at the accepting edge; changes on `lanes_in` during a running operation do not affect the result.
- R5: Addition wraps: 32 lanes of 0xFFFFFFFF give 0xFFFFFFE0, and 32 lanes of 0x80000000 give 0x00000000.
- R6: A start seen while idle with `mask` not equal to 0xFFFFFFFF makes `err` high for the next cycle only, produces no `done`, and leaves `sum` unchanged.
- R7: A start seen while `busy` is high is ignored: no restart, no `err`, and the running operation completes on its original schedule with its original data.
- R8: `done` is a single-cycle pulse, and `sum` holds its value in every cycle in which `done` is low.
- R9: A start presented in the cycle in which `done` is high is accepted, so operations can run back to back every five cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a reduction; acted on only while idle |
| mask | input | 32 | Participation mask; must be all ones for a valid run |
| lanes_in | input | 1024 | Lane values, lane i in bits [32*i+31 : 32*i] |
| busy | output | 1 | Exchange steps in progress |
| done | output | 1 | One-cycle pulse; `sum` is valid from this cycle |
| err | output | 1 | One-cycle pulse for a start rejected by the mask check |
| sum | output | 32 | Warp total taken from lane 0 |

## Verification
The properties assume that `rst` is held for at least one clock before the first start. They also assume that `start` and `mask` are stable across each rising edge, because an accepted start is decided purely from their values at that edge. The stimulus changes every input only at falling clock edges and keeps reset asserted for several cycles, so both assumptions hold throughout the run. The stimulus deliberately sends starts while busy, and starts with bad masks while busy, because the properties treat both as legal inputs that must simply be ignored.

// File: rtl/wred_pkg.sv
package wred_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wred_state_e;

  // Number of halving exchange steps needed to fold n lanes into lane 0.
  function automatic int unsigned fold_steps(input int unsigned n);
    return $clog2(n);
  endfunction
endpackage

// File: rtl/wred_ctrl.sv
module wred_ctrl
  import wred_pkg::*;
#(
  parameter int unsigned STEPS = 5,
  parameter int unsigned SW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mask_ok,
  output logic          load,
  output logic          reject,
  output logic          step_en,
  output logic          last,
  output logic          busy,
  output logic [SW-1:0] step_idx
);
  wred_state_e   state_q;
  logic [SW-1:0] cnt_q;
  logic          idle;

  always_comb begin
    idle     = (state_q == ST_IDLE);
    load     = start && idle && mask_ok;
    reject   = start && idle && !mask_ok;
    step_en  = (state_q == ST_RUN);
    last     = step_en && (cnt_q == SW'(STEPS - 1));
    busy     = step_en;
    step_idx = load ? '0 : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (load) begin
      // first exchange happens at the accepting edge
      state_q <= ST_RUN;
      cnt_q   <= SW'(1);
    end else if (step_en) begin
      if (last) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + SW'(1);
      end
    end
  end

  // R2 / R7: once running, the step counter advances every clock regardless of start
  p_step_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (step_en && !last) |=> (step_en && cnt_q == $past(cnt_q) + SW'(1)));
endmodule

// File: rtl/wred_shfl_step.sv
module wred_shfl_step #(
  parameter int unsigned LANES = 32,
  parameter int unsigned W     = 32,
  parameter int unsigned STEPS = 5,
  parameter int unsigned SW    = 3
) (
  input  logic [LANES-1:0][W-1:0] cur,
  input  logic [SW-1:0]           step_idx,
  output logic [LANES-1:0][W-1:0] nxt
);
  logic [W-1:0] cand [LANES][STEPS];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    for (genvar s = 0; s < STEPS; s++) begin : g_step
      localparam int unsigned OFF = LANES >> (s + 1);
      if (i + OFF < LANES) begin : g_add
        assign cand[i][s] = cur[i] + cur[i+OFF];
      end else begin : g_keep
        assign cand[i][s] = cur[i];
      end
    end

    always_comb begin
      nxt[i] = cur[i];
      for (int s = 0; s < STEPS; s++) begin
        if (step_idx == SW'(s)) nxt[i] = cand[i][s];
      end
    end
  end
endmodule

// File: rtl/wred_lane_bank.sv
module wred_lane_bank #(
  parameter int unsigned LANES = 32,
  parameter int unsigned W     = 32
) (
  input  logic                    clk,
  input  logic                    wr,
  input  logic [LANES-1:0][W-1:0] d,
  output logic [LANES-1:0][W-1:0] q
);
  always_ff @(posedge clk) begin
    if (wr) q <= d;
  end
endmodule

// File: rtl/warp_shfl_reduce.sv
module warp_shfl_reduce
  import wred_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned W     = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [LANES-1:0]   mask,
  input  logic [LANES*W-1:0] lanes_in,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [W-1:0]       sum
);
  localparam int unsigned STEPS = fold_steps(LANES);
  localparam int unsigned SW    = $clog2(STEPS + 1);

  logic                    load, reject, step_en, last, mask_ok;
  logic [SW-1:0]           step_idx;
  logic [LANES-1:0][W-1:0] lane_q, cur_sel, lane_nxt, lanes_vec;
  logic                    done_q, err_q;
  logic [W-1:0]            sum_q;

  assign mask_ok   = &mask;
  assign lanes_vec = lanes_in;
  assign cur_sel   = load ? lanes_vec : lane_q;

  wred_ctrl #(.STEPS(STEPS), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mask_ok(mask_ok),
    .load(load), .reject(reject), .step_en(step_en), .last(last),
    .busy(busy), .step_idx(step_idx)
  );

  wred_shfl_step #(.LANES(LANES), .W(W), .STEPS(STEPS), .SW(SW)) u_step (
    .cur(cur_sel), .step_idx(step_idx), .nxt(lane_nxt)
  );

  wred_lane_bank #(.LANES(LANES), .W(W)) u_bank (
    .clk(clk), .wr(load | step_en), .d(lane_nxt), .q(lane_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      sum_q  <= '0;
    end else begin
      done_q <= last;
      err_q  <= reject;
      if (last) sum_q <= lane_nxt[0];
    end
  end

  assign done = done_q;
  assign err  = err_q;
  assign sum  = sum_q;

  // checker: cycles elapsed since the accepting edge
  logic [SW:0] chk_age;
  always_ff @(posedge clk) begin
    if (rst)                       chk_age <= '0;
    else if (load)                 chk_age <= (SW+1)'(1);
    else if (chk_age != '0 && chk_age <= (SW+1)'(STEPS)) chk_age <= chk_age + (SW+1)'(1);
  end

  p_done_latency_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (chk_age == (SW+1)'(STEPS)));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_sum_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sum));
  p_err_no_done_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> !done);
  p_bad_mask_err_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !(&mask)) |=> err);
  p_busy_start_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !err);

  // R3: a lane whose partner index is past the top keeps its value in that step
  for (genvar i = 0; i < LANES; i++) begin : g_keep_chk
    p_lane_keep_r3: assert property (@(posedge clk) disable iff (rst)
      (step_en && (i + (LANES >> (int'(step_idx) + 1)) >= LANES)) |=> $stable(lane_q[i]));
  end
endmodule

// File: tb/warp_shfl_reduce_test.sv
module warp_shfl_reduce_test;
  localparam int N = 32;
  localparam int W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [N-1:0]     mask = '1;
  logic [N*W-1:0]   lanes_in = '0;
  logic             busy, done, err;
  logic [W-1:0]     sum;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  warp_shfl_reduce uut (
    .clk(clk), .rst(rst), .start(start), .mask(mask), .lanes_in(lanes_in),
    .busy(busy), .done(done), .err(err), .sum(sum)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] mk_ramp();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i + 1);
    return v;
  endfunction

  function automatic logic [N*W-1:0] mk_fill(input logic [W-1:0] x);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = x;
    return v;
  endfunction

  function automatic logic [N*W-1:0] mk_onehot();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(1) << i;
    return v;
  endfunction

  function automatic logic [N*W-1:0] mk_mix(input logic [W-1:0] seed);
    logic [N*W-1:0] v;
    logic [W-1:0] x;
    x = seed;
    for (int i = 0; i < N; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      v[i*W +: W] = x;
    end
    return v;
  endfunction

  function automatic logic [W-1:0] ref_sum(input logic [N*W-1:0] v);
    logic [W-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++) s = s + v[i*W +: W];
    return s;
  endfunction

  // Called at a falling edge: presents a start for the next rising edge.
  task automatic launch(input logic [N*W-1:0] v, input logic [N-1:0] m);
    lanes_in = v;
    mask     = m;
    start    = 1'b1;
  endtask

  // Follows a launch; returns at the falling edge of the done cycle (c+5).
  task automatic follow(input logic [W-1:0] exp, input string tag);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lanes_in = mk_fill(32'h5A5A_5A5A);  // R4: disturbing inputs after capture
    chk({tag, " R2 done low c+1"}, {31'b0, done}, 32'd0);
    chk({tag, " R2 busy high c+1"}, {31'b0, busy}, 32'd1);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      chk({tag, " R2 done low mid"}, {31'b0, done}, 32'd0);
    end
    @(negedge clk);
    chk({tag, " R2 done at c+5"}, {31'b0, done}, 32'd1);
    chk({tag, " R2 busy low at c+5"}, {31'b0, busy}, 32'd0);
    chk({tag, " R3 sum"}, sum, exp);
  endtask

  task automatic t_reset();
    chk("R1 busy in reset", {31'b0, busy}, 32'd0);
    chk("R1 done in reset", {31'b0, done}, 32'd0);
    chk("R1 err in reset", {31'b0, err}, 32'd0);
    chk("R1 sum in reset", sum, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 busy after reset", {31'b0, busy}, 32'd0);
    chk("R1 sum after reset", sum, 32'd0);
  endtask

  task automatic t_ramp();
    launch(mk_ramp(), '1);
    follow(32'd528, "ramp");
    @(negedge clk);
    chk("R8 done single pulse", {31'b0, done}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 sum holds when idle", sum, 32'd528);
  endtask

  task automatic t_patterns();
    logic [N*W-1:0] v;
    launch(mk_onehot(), '1);
    follow(32'hFFFF_FFFF, "onehot R3");
    @(negedge clk);
    v = mk_mix(32'h1234_5678);
    launch(v, '1);
    follow(ref_sum(v), "mix R3");
    @(negedge clk);
  endtask

  task automatic t_wrap();
    launch(mk_fill(32'hFFFF_FFFF), '1);
    follow(32'hFFFF_FFE0, "R5 all ones");
    @(negedge clk);
    launch(mk_fill(32'h8000_0000), '1);
    follow(32'h0000_0000, "R5 msb fill");
    @(negedge clk);
    launch(mk_ramp(), '1);
    follow(32'd528, "restore");
    @(negedge clk);
  endtask

  task automatic t_mask(input logic [N-1:0] m, input string tag);
    launch(mk_onehot(), m);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R6 err pulse"}, {31'b0, err}, 32'd1);
    chk({tag, " R6 not busy"}, {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk({tag, " R6 err one cycle"}, {31'b0, err}, 32'd0);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (done !== 1'b0) chk({tag, " R6 no done"}, {31'b0, done}, 32'd0);
    end
    chk({tag, " R6 sum unchanged"}, sum, 32'd528);
  endtask

  task automatic t_busy_ignore();
    logic [N*W-1:0] a;
    a = mk_mix(32'hCAFE_0001);
    launch(a, '1);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    // second request while running, new data, full mask
    launch(mk_fill(32'h0000_0003), '1);
    @(negedge clk);
    chk("R8 sum holds while busy", sum, 32'd528);
    // another request while running, bad mask
    mask = 32'h0000_0000;
    @(negedge clk);
    chk("R7 no err for busy start", {31'b0, err}, 32'd0);
    start = 1'b0;
    mask = '1;
    @(negedge clk);
    chk("R7 done on original schedule", {31'b0, done}, 32'd1);
    chk("R4 R7 original data kept", sum, ref_sum(a));
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (done !== 1'b0 || busy !== 1'b0) chk("R7 no restart", {30'b0, busy, done}, 32'd0);
    end
    chk("R7 final idle", {31'b0, busy}, 32'd0);
  endtask

  task automatic t_back2back();
    logic [N*W-1:0] b;
    launch(mk_ramp(), '1);
    follow(32'd528, "b2b first");
    b = mk_mix(32'h0BAD_F00D);
    launch(b, '1);  // presented in the done cycle
    follow(ref_sum(b), "R9 b2b second");
    @(negedge clk);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=hung expected=finish");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ramp();
    t_patterns();
    t_wrap();
    t_mask(32'hFFFF_FFFE, "lane0 off");
    t_mask(32'h0000_0000, "all off");
    t_mask(32'h7FFF_FFFF, "lane31 off");
    t_busy_ignore();
    t_back2back();
    finished = 1'b1;
    report();
  end
endmodule